// File: doc/BRIEF.md
# Stack Call/Return Sequencer

This block carries out the stack side of three control-transfer operations of a 16-bit segmented processor: a near call, a near return and a far return. The pipeline hands it an operation code together with the current instruction pointer (already pointing past the transfer instruction), code segment, stack segment, stack pointer and, for a call, a signed 16-bit displacement. The block then works through a short sequence of cycles on a synchronous word-wide memory port. Each cycle makes at most one access. When the sequence is over, the new instruction pointer, code segment and stack pointer are on its outputs and a done strobe is high for one cycle.

Every memory address is a physical byte address. It is formed by shifting a segment left by four bits and adding a 16-bit offset, and the result is kept to 20 bits. A word access reads or writes the byte at that address as the low byte and the next byte up as the high byte. The sequencer accepts a new operation only when it is idle. Its outputs keep their values until the next operation is accepted.

Top module: `callret_unit`

## Requirements
- R1: While reset is held low and in the first cycle after it is released, done and mem_en are 0 and ip_out, cs_out and sp_out are all 0.
- R2: Every memory address equals (segment * 16 + offset) mod 2^20, with the stack segment as the segment. The word sits little-endian in memory: the low byte is at the address and the high byte at the address plus 1.
- R3: A near call (op = 0) makes exactly one access, a write, in the first cycle after the start edge. The write data is ip_in and the address is SS:(SP-2). The 16-bit subtraction wraps, so SP = 0 gives offset 0xFFFE. When the call is done, sp_out is SP-2 mod 2^16.
- R4: When a near call is done, ip_out equals (ip_in + disp) mod 2^16 and cs_out equals cs_in.
- R5: A near return (op = 1) reads the word at SS:SP in the first cycle after the start edge. When it is done, ip_out is that word, sp_out is SP+2 mod 2^16 and cs_out equals cs_in.
- R6: A far return (op = 2) reads the word at SS:SP in the first cycle after the start edge and loads it into IP. It reads the word at SS:(SP+2) in the second cycle and loads it into CS. When it is done, sp_out is SP+4 mod 2^16.
- R7: done is high for exactly one cycle. For op 0, 1, 2 and 3 it rises in cycle 2, 3, 4 and 1 after the start edge, respectively.
- R8: Op code 3 is reserved. It makes no memory access, and when it is done the outputs equal ip_in, cs_in and sp_in as sampled at the start edge.
- R9: A start that arrives while an operation is in progress has no effect on the accesses or the results. While the block is idle, the outputs hold the results of the last operation.
- R10: mem_en is high only in the access cycles given in R3, R5 and R6, and never in the done cycle. mem_we is high only during the write of a near call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| op | input | 2 | 0 near call, 1 near return, 2 far return, 3 reserved |
| disp | input | 16 | Signed call displacement |
| ip_in | input | 16 | Current IP (address of the next instruction) |
| cs_in | input | 16 | Current code segment |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack pointer |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 20 | Physical byte address of the word |
| mem_wdata | output | 16 | Word to write |
| mem_rdata | input | 16 | Word read, valid the cycle after a read |
| ip_out | output | 16 | Updated instruction pointer |
| cs_out | output | 16 | Updated code segment |
| sp_out | output | 16 | Updated stack pointer |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench pushes a stack pointer of zero to check the offset wrap to 0xFFFE. A design that moved the pointer after the write, or that failed to wrap, would put the saved IP at the wrong word. It adds a negative displacement so that IP wraps below zero, and it places a stack segment near the top of memory so that the physical address has to drop its 21st bit. A far return is issued with a stray start pulse in the middle of it: a design that popped CS before IP, or that let the stray start restart the sequence, would show swapped segment and pointer values or a second access. A call followed by a return over the same word checks that the byte order written matches the byte order read back.

// File: rtl/callret_pkg.sv
package callret_pkg;

   typedef enum logic [1:0] {
      OP_NCALL = 2'd0,
      OP_NRET  = 2'd1,
      OP_FRET  = 2'd2,
      OP_RSVD  = 2'd3
   } xfer_op_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PUSH  = 3'd1,
      ST_RD_IP = 3'd2,
      ST_RD_CS = 3'd3,
      ST_LAND  = 3'd4,
      ST_DONE  = 3'd5
   } seq_state_e;

endpackage

// File: rtl/callret_agen.sv
module callret_agen #(
   parameter int AW    = 20,
   parameter int DW    = 16,
   parameter int SHIFT = 4
) (
   input  logic [DW-1:0] seg,
   input  logic [DW-1:0] off,
   output logic [AW-1:0] phys
);
   localparam int FULL = DW + SHIFT + 1;

   logic [FULL-1:0] sum;

   assign sum = {1'b0, seg, {SHIFT{1'b0}}} + {{(SHIFT + 1){1'b0}}, off};

   generate
      if (AW <= FULL) begin : g_trunc
         assign phys = sum[AW-1:0];
      end else begin : g_extend
         assign phys = {{(AW - FULL){1'b0}}, sum};
      end
   endgenerate
endmodule

// File: rtl/callret_fsm.sv
module callret_fsm
   import callret_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  xfer_op_e   op,
   output seq_state_e st,
   output xfer_op_e   op_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         op_q <= OP_NCALL;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  op_q <= op;
                  unique case (op)
                     OP_NCALL: st <= ST_PUSH;
                     OP_NRET,
                     OP_FRET:  st <= ST_RD_IP;
                     default:  st <= ST_DONE;
                  endcase
               end
            end
            ST_PUSH:  st <= ST_DONE;
            ST_RD_IP: st <= (op_q == OP_FRET) ? ST_RD_CS : ST_LAND;
            ST_RD_CS: st <= ST_LAND;
            ST_LAND:  st <= ST_DONE;
            default:  st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/callret_dpath.sv
module callret_dpath
   import callret_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  seq_state_e    st,
   input  xfer_op_e      op_q,
   input  logic [DW-1:0] disp,
   input  logic [DW-1:0] ip_in,
   input  logic [DW-1:0] cs_in,
   input  logic [DW-1:0] ss_in,
   input  logic [DW-1:0] sp_in,
   input  logic [DW-1:0] rdata,
   output logic [DW-1:0] ip_q,
   output logic [DW-1:0] cs_q,
   output logic [DW-1:0] ss_q,
   output logic [DW-1:0] sp_q,
   output logic [DW-1:0] off
);
   localparam logic [DW-1:0] STEP = DW'(DW / 8);

   logic [DW-1:0] disp_q;

   assign off = (st == ST_PUSH) ? sp_q - STEP : sp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ip_q   <= '0;
         cs_q   <= '0;
         ss_q   <= '0;
         sp_q   <= '0;
         disp_q <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  ip_q   <= ip_in;
                  cs_q   <= cs_in;
                  ss_q   <= ss_in;
                  sp_q   <= sp_in;
                  disp_q <= disp;
               end
            end
            ST_PUSH: begin
               sp_q <= sp_q - STEP;
               ip_q <= ip_q + disp_q;
            end
            ST_RD_IP: sp_q <= sp_q + STEP;
            ST_RD_CS: begin
               ip_q <= rdata;
               sp_q <= sp_q + STEP;
            end
            ST_LAND: begin
               if (op_q == OP_FRET) cs_q <= rdata;
               else                 ip_q <= rdata;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/callret_unit.sv
module callret_unit
   import callret_pkg::*;
#(
   parameter int AW    = 20,
   parameter int DW    = 16,
   parameter int SHIFT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    op,
   input  logic [DW-1:0] disp,
   input  logic [DW-1:0] ip_in,
   input  logic [DW-1:0] cs_in,
   input  logic [DW-1:0] ss_in,
   input  logic [DW-1:0] sp_in,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] ip_out,
   output logic [DW-1:0] cs_out,
   output logic [DW-1:0] sp_out,
   output logic          done
);
   generate
      if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
         $error("callret_unit: DW must be a positive multiple of 8");
      end
      if (SHIFT < 0 || AW < DW) begin : g_bad_aw
         $error("callret_unit: AW must cover DW and SHIFT must be non-negative");
      end
   endgenerate

   seq_state_e    st;
   xfer_op_e      op_q;
   logic [DW-1:0] ip_q, cs_q, ss_q, sp_q, off;

   callret_fsm u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .op    (xfer_op_e'(op)),
      .st    (st),
      .op_q  (op_q)
   );

   callret_dpath #(.DW(DW)) u_dpath (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .st    (st),
      .op_q  (op_q),
      .disp  (disp),
      .ip_in (ip_in),
      .cs_in (cs_in),
      .ss_in (ss_in),
      .sp_in (sp_in),
      .rdata (mem_rdata),
      .ip_q  (ip_q),
      .cs_q  (cs_q),
      .ss_q  (ss_q),
      .sp_q  (sp_q),
      .off   (off)
   );

   callret_agen #(.AW(AW), .DW(DW), .SHIFT(SHIFT)) u_agen (
      .seg  (ss_q),
      .off  (off),
      .phys (mem_addr)
   );

   assign mem_en    = (st == ST_PUSH) || (st == ST_RD_IP) || (st == ST_RD_CS);
   assign mem_we    = (st == ST_PUSH);
   assign mem_wdata = ip_q;
   assign done      = (st == ST_DONE);
   assign ip_out    = ip_q;
   assign cs_out    = cs_q;
   assign sp_out    = sp_q;
endmodule

// File: rtl/callret_chk.sv
module callret_chk #(
   parameter int AW    = 20,
   parameter int DW    = 16,
   parameter int SHIFT = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [1:0]    op,
   input logic [DW-1:0] disp,
   input logic [DW-1:0] ip_in,
   input logic [DW-1:0] ss_in,
   input logic [DW-1:0] sp_in,
   input logic          mem_en,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic [DW-1:0] ip_out,
   input logic [DW-1:0] sp_out,
   input logic          done
);
   localparam logic [DW-1:0] STEP = DW'(DW / 8);

   function automatic logic [AW-1:0] to_phys(logic [DW-1:0] seg, logic [DW-1:0] ofs);
      longint unsigned s;
      s = (longint'(seg) << SHIFT) + longint'(ofs);
      return AW'(s);
   endfunction

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_WRITE_FROM_CALL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($past(start) && $past(op) == 2'd0 && mem_wdata == $past(ip_in))); // R3

   AST_WRITE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_addr == to_phys($past(ss_in), $past(sp_in) - STEP)); // R2

   AST_CALL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (done && ip_out == DW'($past(ip_in, 2) + $past(disp, 2))
                  && sp_out == DW'($past(sp_in, 2) - STEP))); // R4

   AST_QUIET_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_en); // R10
endmodule

bind callret_unit callret_chk #(.AW(AW), .DW(DW), .SHIFT(SHIFT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .op        (op),
   .disp      (disp),
   .ip_in     (ip_in),
   .ss_in     (ss_in),
   .sp_in     (sp_in),
   .mem_en    (mem_en),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .ip_out    (ip_out),
   .sp_out    (sp_out),
   .done      (done)
);

// File: tb/test_callret_unit.sv
module test_callret_unit;
   localparam int CLK_PERIOD = 10;
   localparam int AMASK = 20'hFFFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'd0;
   logic [15:0] disp = '0, ip_in = '0, cs_in = '0, ss_in = '0, sp_in = '0;
   logic        mem_en, mem_we, done;
   logic [19:0] mem_addr;
   logic [15:0] mem_wdata, mem_rdata, ip_out, cs_out, sp_out;

   int checks = 0;
   int errors = 0;
   bit chk_on = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   callret_unit i_callret_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .disp(disp),
      .ip_in(ip_in), .cs_in(cs_in), .ss_in(ss_in), .sp_in(sp_in),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .ip_out(ip_out), .cs_out(cs_out), .sp_out(sp_out), .done(done)
   );

   // memory serving the design: byte array, little-endian words
   byte unsigned ram[int];
   byte unsigned ref_mem[int];

   function automatic int rd_byte(input bit from_ref, input int a);
      if (from_ref) return ref_mem.exists(a) ? int'(ref_mem[a]) : 0;
      return ram.exists(a) ? int'(ram[a]) : 0;
   endfunction

   function automatic int ref_word(input int a);
      return rd_byte(1'b1, a) | (rd_byte(1'b1, (a + 1) & AMASK) << 8);
   endfunction

   function automatic void poke(input int a, input int w);
      ram[a] = byte'(w & 8'hFF);
      ram[(a + 1) & AMASK] = byte'((w >> 8) & 8'hFF);
      ref_mem[a] = byte'(w & 8'hFF);
      ref_mem[(a + 1) & AMASK] = byte'((w >> 8) & 8'hFF);
   endfunction

   function automatic int phys(input int seg, input int ofs);
      return ((seg << 4) + (ofs & 16'hFFFF)) & AMASK;
   endfunction

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) begin
            ram[int'(mem_addr)] = byte'(mem_wdata[7:0]);
            ram[(int'(mem_addr) + 1) & AMASK] = byte'(mem_wdata[15:8]);
         end else begin
            mem_rdata <= 16'(rd_byte(1'b0, int'(mem_addr)) | (rd_byte(1'b0, (int'(mem_addr) + 1) & AMASK) << 8));
         end
      end
   end

   typedef struct {
      bit    en, we, dn;
      int    addr, wdata, ip, cs, sp;
      string tag;
   } exp_t;

   exp_t expq[$];
   int last_ip = 0, last_cs = 0, last_sp = 0;

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic exp_t mk(input bit en, input bit we, input int addr, input int wd, input string tag);
      exp_t e;
      e.en = en; e.we = we; e.dn = 1'b0; e.addr = addr; e.wdata = wd;
      e.ip = 0; e.cs = 0; e.sp = 0; e.tag = tag;
      return e;
   endfunction

   function automatic exp_t mk_done(input int ip, input int cs, input int sp, input string tag);
      exp_t e;
      e = mk(1'b0, 1'b0, 0, 0, tag);
      e.dn = 1'b1; e.ip = ip & 16'hFFFF; e.cs = cs & 16'hFFFF; e.sp = sp & 16'hFFFF;
      return e;
   endfunction

   // per-cycle comparison against the reference expectations
   always @(negedge clk) begin
      if (chk_on) begin
         exp_t e;
         bit   idle;
         idle = (expq.size() == 0);
         if (idle) begin
            e = mk(1'b0, 1'b0, 0, 0, "R9");
            e.ip = last_ip; e.cs = last_cs; e.sp = last_sp;
         end else begin
            e = expq.pop_front();
         end
         check(mem_en == e.en, "R10", "mem_en", int'(mem_en), int'(e.en));
         check(done == e.dn, "R7", "done", int'(done), int'(e.dn));
         if (e.en) begin
            check(mem_we == e.we, e.tag, "mem_we", int'(mem_we), int'(e.we));
            check(int'(mem_addr) == e.addr, "R2", "mem_addr", int'(mem_addr), e.addr);
            if (e.we) check(int'(mem_wdata) == e.wdata, e.tag, "mem_wdata", int'(mem_wdata), e.wdata);
         end
         if (idle || e.dn) begin
            check(int'(ip_out) == e.ip, e.tag, "ip_out", int'(ip_out), e.ip);
            check(int'(cs_out) == e.cs, e.tag, "cs_out", int'(cs_out), e.cs);
            check(int'(sp_out) == e.sp, e.tag, "sp_out", int'(sp_out), e.sp);
            last_ip = e.ip; last_cs = e.cs; last_sp = e.sp;
         end
      end
   end

   // issue one operation and queue the expected cycles
   task automatic run(input int o, input int ip, input int cs, input int ss, input int sp,
                      input int d, input bit intrude);
      int n;
      @(negedge clk); #1;
      op = 2'(o); ip_in = 16'(ip); cs_in = 16'(cs); ss_in = 16'(ss); sp_in = 16'(sp);
      disp = 16'(d); start = 1'b1;
      case (o)
         0: begin // R3, R4
            int a;
            a = phys(ss, sp - 2);
            expq.push_back(mk(1'b1, 1'b1, a, ip & 16'hFFFF, "R3"));
            expq.push_back(mk_done(ip + d, cs, sp - 2, "R4"));
            ref_mem[a] = byte'(ip & 8'hFF);
            ref_mem[(a + 1) & AMASK] = byte'((ip >> 8) & 8'hFF);
            n = 2;
         end
         1: begin // R5
            expq.push_back(mk(1'b1, 1'b0, phys(ss, sp), 0, "R5"));
            expq.push_back(mk(1'b0, 1'b0, 0, 0, "R5"));
            expq.push_back(mk_done(ref_word(phys(ss, sp)), cs, sp + 2, "R5"));
            n = 3;
         end
         2: begin // R6: IP word first, CS word second
            expq.push_back(mk(1'b1, 1'b0, phys(ss, sp), 0, "R6"));
            expq.push_back(mk(1'b1, 1'b0, phys(ss, sp + 2), 0, "R6"));
            expq.push_back(mk(1'b0, 1'b0, 0, 0, "R6"));
            expq.push_back(mk_done(ref_word(phys(ss, sp)), ref_word(phys(ss, sp + 2)), sp + 4, "R6"));
            n = 4;
         end
         default: begin // R8
            expq.push_back(mk_done(ip, cs, sp, "R8"));
            n = 1;
         end
      endcase
      @(negedge clk); #1;
      ip_in = ~ip_in; sp_in = ~sp_in; ss_in = ~ss_in; cs_in = ~cs_in; disp = ~disp;
      if (intrude) begin // R9: stray start while busy
         op = 2'd0; start = 1'b1;
         @(negedge clk); #1;
      end
      start = 1'b0;
      repeat (n + 1) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(done == 1'b0, "R1", "done in reset", int'(done), 0);
      check(mem_en == 1'b0, "R1", "mem_en in reset", int'(mem_en), 0);
      check(ip_out == 16'h0 && cs_out == 16'h0 && sp_out == 16'h0, "R1", "outputs in reset",
            int'(ip_out | cs_out | sp_out), 0);
      #1 rst_n = 1'b1;
      chk_on = 1'b1;
      repeat (2) @(negedge clk);

      run(0, 16'h0234, 16'h2000, 16'h1000, 16'h0100, 16'h0010, 1'b0); // R3 R4 plain call
      run(1, 0, 16'h2000, 16'h1000, 16'h00FE, 0, 1'b0);               // R5 pops the word just pushed
      run(0, 16'h0005, 16'h3000, 16'h1200, 16'h0040, 16'hFFF0, 1'b0); // R4 negative disp wrap
      run(0, 16'hBEEF, 16'h3000, 16'h0800, 16'h0000, 16'h0002, 1'b0); // R3 SP wraps to FFFE
      run(1, 0, 16'h3000, 16'h0800, 16'hFFFE, 0, 1'b0);               // R5 SP wraps to 0000
      poke(phys(16'h0500, 16'h0200), 16'h1234);
      poke(phys(16'h0500, 16'h0202), 16'hABCD);
      run(2, 0, 16'h7777, 16'h0500, 16'h0200, 0, 1'b0);               // R6 far return
      poke(phys(16'hFFFF, 16'h0020), 16'h5A01);
      run(1, 0, 16'h0001, 16'hFFFF, 16'h0020, 0, 1'b0);               // R2 physical wrap
      run(3, 16'h4321, 16'h8765, 16'h0100, 16'h0C0C, 16'h0003, 1'b0); // R8 reserved op
      poke(phys(16'h0900, 16'hFFFC), 16'h0F0E);
      poke(phys(16'h0900, 16'hFFFE), 16'hC0DE);
      run(2, 0, 16'h1111, 16'h0900, 16'hFFFC, 0, 1'b1);               // R6 R9 stray start
      repeat (4) @(negedge clk);                                      // R9 idle hold

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule